// File: doc/BRIEF.md
# Configurable External Interrupt Controller

The block watches a bank of asynchronous interrupt pins and converts each into a clocked request. Every pin is first brought into the clock domain by a two-flop synchronizer. A per-line detector then fires on a rising edge, a falling edge, a high level or a low level, chosen by three configuration bits per line. A fired detector sets a sticky flag for that line. The flag reaches the line's request output only when two separate gates are both open: the line must be armed, which turns detection on, and unmasked, which lets the request propagate.

Software reaches the block through a flat register port with a single address and an N-bit data word. Each write takes one cycle, and read data is available combinationally from the current address. Both gates are controlled through write-one-to-set and write-one-to-clear registers, so several lines can be changed in one write without disturbing the others. A debug freeze input stops pin sampling and flag setting while a debugger holds the system. A keep-running input cancels the freeze.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, the mode, edge, level, armed, unmask and flag registers all read zero, and every irq output is low.
- R2: The per-line mode register at offset 0 selects the detector: 0 selects edge detection and 1 selects level detection. The edge register at offset 1 and the level register at offset 2 are read/write and read back as written.
- R3: In edge mode, edge bit 1 fires on a rising pin and edge bit 0 fires on a falling pin. A pin change applied before clock edge k becomes visible in the flag after edge k+2.
- R4: In level mode, level bit 1 fires while the synchronized pin is high and level bit 0 fires while it is low. A flag cleared while the level persists is set again.
- R5: A write of ones to offset 3 arms those lines. A write of ones to offset 4 disarms them. Offset 5 reads the armed set. Zero bits in any set or clear write leave the line unchanged.
- R6: A write of ones to offset 6 unmasks those lines. A write of ones to offset 7 masks them. Offset 8 reads the unmask set.
- R7: irq_o[n] is high exactly when flag n, armed n and unmask n are all set. irq_any_o is the OR of irq_o.
- R8: The flags at offset 9 are sticky. A flag falls only when a one is written to that bit at offset 10, or when the line is disarmed. A trigger in the same cycle as a clear wins.
- R9: Disarming a line clears its flag at the same clock edge. A disarmed line never sets its flag.
- R10: While frz_i is high and frz_run_i is low, pin sampling is held and no flag is set, but register writes still take effect. When frz_i is high and frz_run_i is also high, the block runs normally.
- R11: Write-only offsets (3, 4, 6, 7, 10) and unused offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | N | Asynchronous interrupt pins |
| frz_i | input | 1 | Debug freeze request |
| frz_run_i | input | 1 | Keep running despite freeze |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register offset for read and write |
| wdata_i | input | N | Write data, one bit per line |
| rdata_o | output | N | Read data for addr_i |
| irq_o | output | N | Per-line request |
| irq_any_o | output | 1 | OR of all per-line requests |

## Verification
The bench builds the block with its defaults: eight lines and a four-bit offset. Eight lines are enough to cover every trigger kind at once: two rising-edge lines, two falling-edge lines, two high-level lines and two low-level lines. With these defaults, a single write can arm some lines while others stay idle, which shows that zero bits have no effect. The four-bit offset leaves five unused offsets, which can be probed for zero reads. A random phase then mixes pin changes, every register write and freeze toggles, which exercises clear-versus-trigger and disarm-versus-trigger collisions against the reference model.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int N  = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pin_i,
  input  logic          frz_i,
  input  logic          frz_run_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [N-1:0]  wdata_i,
  output logic [N-1:0]  rdata_o,
  output logic [N-1:0]  irq_o,
  output logic          irq_any_o
);
  localparam logic [AW-1:0] A_MODE = AW'(0);
  localparam logic [AW-1:0] A_EDGE = AW'(1);
  localparam logic [AW-1:0] A_LVL  = AW'(2);
  localparam logic [AW-1:0] A_ASET = AW'(3);
  localparam logic [AW-1:0] A_ACLR = AW'(4);
  localparam logic [AW-1:0] A_ARMD = AW'(5);
  localparam logic [AW-1:0] A_USET = AW'(6);
  localparam logic [AW-1:0] A_UCLR = AW'(7);
  localparam logic [AW-1:0] A_UNMK = AW'(8);
  localparam logic [AW-1:0] A_FLAG = AW'(9);
  localparam logic [AW-1:0] A_FCLR = AW'(10);

  logic [N-1:0] mode_q, edge_q, lvl_q, armed_q, unmask_q, flag_q;
  logic [N-1:0] s1_q, s2_q, s3_q;
  logic [N-1:0] arm_set, arm_clr, unm_set, unm_clr, flg_clr;
  logic [N-1:0] armed_d, unmask_d, flag_d, trig;
  logic         halted;

  assign halted  = frz_i & ~frz_run_i;
  assign arm_set = (wr_en_i && addr_i == A_ASET) ? wdata_i : '0;
  assign arm_clr = (wr_en_i && addr_i == A_ACLR) ? wdata_i : '0;
  assign unm_set = (wr_en_i && addr_i == A_USET) ? wdata_i : '0;
  assign unm_clr = (wr_en_i && addr_i == A_UCLR) ? wdata_i : '0;
  assign flg_clr = (wr_en_i && addr_i == A_FCLR) ? wdata_i : '0;

  assign armed_d  = (armed_q | arm_set) & ~arm_clr;
  assign unmask_d = (unmask_q | unm_set) & ~unm_clr;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (mode_q[i]) trig[i] = (s2_q[i] == lvl_q[i]);
      else           trig[i] = edge_q[i] ? (s2_q[i] & ~s3_q[i]) : (~s2_q[i] & s3_q[i]);
    end
  end

  assign flag_d = ((flag_q & ~flg_clr) | (trig & armed_q & {N{~halted}})) & armed_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else if (!halted) begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      edge_q   <= '0;
      lvl_q    <= '0;
      armed_q  <= '0;
      unmask_q <= '0;
      flag_q   <= '0;
    end else begin
      if (wr_en_i && addr_i == A_MODE) mode_q <= wdata_i;
      if (wr_en_i && addr_i == A_EDGE) edge_q <= wdata_i;
      if (wr_en_i && addr_i == A_LVL)  lvl_q  <= wdata_i;
      armed_q  <= armed_d;
      unmask_q <= unmask_d;
      flag_q   <= flag_d;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_MODE:  rdata_o = mode_q;
      A_EDGE:  rdata_o = edge_q;
      A_LVL:   rdata_o = lvl_q;
      A_ARMD:  rdata_o = armed_q;
      A_UNMK:  rdata_o = unmask_q;
      A_FLAG:  rdata_o = flag_q;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o     = flag_q & armed_q & unmask_q;
  assign irq_any_o = |irq_o;
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk #(
  parameter int N  = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          halted,
  input logic          wr_en_i,
  input logic [AW-1:0] addr_i,
  input logic [N-1:0]  wdata_i,
  input logic [N-1:0]  armed_q,
  input logic [N-1:0]  unmask_q,
  input logic [N-1:0]  flag_q,
  input logic [N-1:0]  irq_o
);
  logic [N-1:0] drop_ok;
  assign drop_ok = (wr_en_i && (addr_i == AW'(10) || addr_i == AW'(4))) ? wdata_i : '0;

  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (armed_q == '0 && unmask_q == '0 && flag_q == '0));

  assert_flag_needs_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q & ~armed_q) == '0);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_q) & ~flag_q & ~$past(drop_ok)) == '0);

  assert_freeze_no_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(halted) |-> (flag_q & ~$past(flag_q)) == '0);

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~(flag_q & unmask_q)) == '0);
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .halted(halted), .wr_en_i(wr_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .armed_q(armed_q),
  .unmask_q(unmask_q), .flag_q(flag_q), .irq_o(irq_o)
);

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;
  localparam int N = 8;
  localparam int AW = 4;
  localparam time PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] pins = '0, wdata = '0;
  logic frz = 0, frz_run = 0, wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [N-1:0] rdata, irq;
  logic irq_any;

  int errors = 0, checks = 0;
  bit done = 0;

  ext_irq_ctrl #(.N(N), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .frz_i(frz), .frz_run_i(frz_run),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .irq_any_o(irq_any));

  always #(PERIOD/2) clk = ~clk;

  // reference model
  logic [N-1:0] m_mode, m_edge, m_lvl, m_arm, m_unm, m_flag;
  logic [N-1:0] hist[$];

  function automatic logic [N-1:0] m_read(input logic [AW-1:0] a);
    case (a)
      0: return m_mode;
      1: return m_edge;
      2: return m_lvl;
      5: return m_arm;
      8: return m_unm;
      9: return m_flag;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = '0; m_edge = '0; m_lvl = '0; m_arm = '0; m_unm = '0; m_flag = '0;
      hist = '{'0, '0, '0};
    end else begin
      logic halt;
      logic [N-1:0] fire, na;
      halt = frz && !frz_run;
      for (int i = 0; i < N; i++) begin
        bit cur, prev;
        cur = hist[1][i];
        prev = hist[2][i];
        if (m_mode[i]) fire[i] = (cur == m_lvl[i]);
        else if (m_edge[i]) fire[i] = cur && !prev;
        else fire[i] = !cur && prev;
      end
      if (halt) fire = '0;
      fire = fire & m_arm;
      na = m_arm;
      if (wr_en) begin
        if (addr == 3) na = na | wdata;
        if (addr == 4) na = na & ~wdata;
        if (addr == 10) m_flag = m_flag & ~wdata;
      end
      m_flag = (m_flag | fire) & na;
      m_arm = na;
      if (wr_en) begin
        if (addr == 0) m_mode = wdata;
        if (addr == 1) m_edge = wdata;
        if (addr == 2) m_lvl = wdata;
        if (addr == 6) m_unm = m_unm | wdata;
        if (addr == 7) m_unm = m_unm & ~wdata;
      end
      if (!halt) begin
        hist.push_front(pins);
        void'(hist.pop_back());
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [N-1:0] ei;
      ei = m_flag & m_arm & m_unm;
      checks++;
      if (irq !== ei || irq_any !== (|ei)) begin
        errors++;
        $display("FAIL R7 model irq=%h any=%b expected irq=%h any=%b", irq, irq_any, ei, |ei);
      end
      checks++;
      if (rdata !== m_read(addr)) begin
        errors++;
        $display("FAIL R11 model rdata@%0d=%h expected %h", addr, rdata, m_read(addr));
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
    addr = a; wdata = d; wr_en = 1;
    tick(1);
    wr_en = 0; wdata = '0;
  endtask

  task automatic chk_rd(input logic [AW-1:0] a, input logic [N-1:0] exp, input string tag);
    addr = a;
    #1;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s rdata@%0d=%h expected %h", tag, a, rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic [N-1:0] exp, input string tag);
    checks++;
    if (irq !== exp || irq_any !== (|exp)) begin
      errors++;
      $display("FAIL %s irq=%h any=%b expected %h %b", tag, irq, irq_any, exp, |exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R1
    chk_rd(5, '0, "R1"); chk_rd(8, '0, "R1"); chk_rd(9, '0, "R1"); chk_irq('0, "R1");
    // R2 configuration
    wr(0, 8'hF0); wr(1, 8'h05); wr(2, 8'h50);
    chk_rd(0, 8'hF0, "R2"); chk_rd(1, 8'h05, "R2"); chk_rd(2, 8'h50, "R2");
    pins = 8'hA0;
    tick(4);
    wr(3, 8'hFF); wr(6, 8'hFF);
    wr(3, 8'h00);
    chk_rd(5, 8'hFF, "R5"); chk_rd(8, 8'hFF, "R6");
    tick(4);
    chk_rd(9, 8'h00, "R4");
    // R3 rising edge latency
    pins = 8'hA1;
    tick(2);
    chk_rd(9, 8'h00, "R3");
    tick(1);
    chk_rd(9, 8'h01, "R3");
    chk_irq(8'h01, "R7");
    // R3 falling edge
    pins = 8'hA3; tick(4);
    chk_rd(9, 8'h01, "R3");
    pins = 8'hA1; tick(4);
    chk_rd(9, 8'h03, "R3");
    // R8 sticky clear
    wr(10, 8'h00);
    chk_rd(9, 8'h03, "R8");
    wr(10, 8'h01);
    chk_rd(9, 8'h02, "R8");
    // R4 level re-fire
    pins = 8'hB1; tick(4);
    chk_rd(9, 8'h12, "R4");
    wr(10, 8'h10); tick(1);
    chk_rd(9, 8'h12, "R4");
    pins = 8'hA1; tick(4);
    wr(10, 8'h10);
    chk_rd(9, 8'h02, "R4");
    // R6 mask
    wr(7, 8'h02);
    chk_irq(8'h00, "R6");
    chk_rd(9, 8'h02, "R6");
    chk_rd(8, 8'hFD, "R6");
    // R9 disarm
    wr(4, 8'h02);
    chk_rd(9, 8'h00, "R9"); chk_rd(5, 8'hFD, "R9");
    pins = 8'hA3; tick(4); pins = 8'hA1; tick(4);
    chk_rd(9, 8'h00, "R9");
    // R10 freeze
    frz = 1;
    pins = 8'hA5; tick(6);
    chk_rd(9, 8'h00, "R10");
    wr(6, 8'h02);
    chk_rd(8, 8'hFF, "R10");
    frz = 0; tick(4);
    chk_rd(9, 8'h04, "R10");
    wr(10, 8'h04);
    pins = 8'hA4; tick(4);
    frz = 1; frz_run = 1;
    pins = 8'hA5; tick(4);
    chk_rd(9, 8'h01, "R10");
    frz = 0; frz_run = 0;
    // R11
    chk_rd(3, '0, "R11"); chk_rd(10, '0, "R11"); chk_rd(15, '0, "R11");
    // random phase, compared against the model every cycle
    for (int k = 0; k < 3000; k++) begin
      pins = N'($urandom);
      frz = ($urandom % 16) == 0;
      frz_run = ($urandom % 2) == 0;
      addr = AW'($urandom % 12);
      wdata = N'($urandom);
      wr_en = ($urandom % 3) == 0;
      tick(1);
    end
    wr_en = 0;
    tick(2);
    finish_run();
  end
endmodule